// File: doc/BRIEF.md
# Trigger Arm and Clock Synchronizer

This block starts a delay cycle. It takes an external trigger that has already been turned into a logic level, and a trigger bit written by a processor. It picks the edge that counts and decides whether the trigger is accepted. An accepted trigger sets a busy flag that the processor can read. The block then moves the asynchronous moment of the trigger onto the master clock grid, so the downstream delay counters start on a clean clock edge.

The whole block runs on a fast sampling clock. It divides that clock by `DIV` to make the master clock, which it reports as a one-cycle `master_tick` strobe. A single processor bit does two jobs:
- With the external path enabled, the bit chooses the edge polarity of the external input.
- With the external path disabled, a falling edge of the bit is the internal trigger, and each single 1-to-0 step is one single shot.

An accepted trigger raises a jitter pulse and loads a one into a two-stage shift register that advances on master ticks. The output of that register ends the jitter pulse. It also gates master ticks onto five channel lines, in the order T0, A, B, C, D. When the pulse ends, its width is reported as a count of sampling-clock cycles. The width always falls between one and two master periods, so a later stage can use it as a measure of the trigger-to-clock offset.

Top module: `trig_arm_sync`

## Requirements
- R1: With `ext_en`=1 and `trig_pol`=1, a rising edge of the synchronized `ext_trig_in` is a trigger, and a falling edge is not.
- R2: With `ext_en`=1 and `trig_pol`=0, a falling edge of the synchronized `ext_trig_in` is a trigger, and a rising edge is not.
- R3: With `ext_en`=0, `ext_trig_in` has no effect, and a 1-to-0 step of `trig_pol` is one trigger (single shot). A 0-to-1 step is not a trigger.
- R4: While `inhibit`=1, no trigger of any mode is accepted, and `busy` stays 0.
- R5: An accepted trigger sets `busy`, which then holds until `clr` or reset. Triggers that arrive while `busy`=1 are ignored and produce no further width report.
- R6: The jitter pulse rises with `busy` and falls on the second `master_tick` after acceptance. That edge also raises `start`. One cycle later, `jit_done` pulses for one cycle with `jit_width` equal to the pulse length in sampling cycles, which lies in the range DIV+1 to 2*DIV.
- R7: Bits 0 to 4 of `chan_tick` serve channels T0, A, B, C and D. They pulse together, one sampling cycle after each `master_tick` while `start`=1, which gives one pulse per master period. No bit pulses while `start`=0.
- R8: `clr` clears `busy`, the jitter pulse, `start` and `chan_tick` on the next edge. A trigger that would be accepted on that same edge is dropped, and a pulse cut short by `clr` produces no width report.
- R9: After a synchronous reset, `busy`, `jitter_pulse`, `start`, `chan_tick` and `jit_done` are 0.
- R10: A 1-to-0 step of `trig_pol` with `ext_en`=0, applied before clock edge N, shows `busy`=1 after edge N+1 and not after edge N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_trig_in | input | 1 | Digitized external trigger, asynchronous |
| ext_en | input | 1 | 1 selects the external path, 0 the internal bit |
| trig_pol | input | 1 | Edge polarity (external) or internal trigger bit |
| inhibit | input | 1 | Blocks all triggers when 1 |
| clr | input | 1 | Processor clear strobe |
| master_tick | output | 1 | One-cycle strobe per master clock period |
| busy | output | 1 | Timing cycle in progress |
| jitter_pulse | output | 1 | Trigger-to-clock jitter pulse |
| start | output | 1 | Clock-aligned start of the delay cycle |
| chan_tick | output | NUM_CHAN | Gated master ticks, T0 at bit 0 through D at bit 4 |
| jit_width | output | $clog2(2*DIV+1) | Last jitter pulse length in sampling cycles |
| jit_done | output | 1 | One-cycle strobe when jit_width is updated |

## Verification
Two functions can land on the same edge: the processor clear and the acceptance of a new trigger. The bench lowers the internal trigger bit one cycle ahead and holds `clr` high for exactly the edge on which the detected edge would be accepted. It then expects `busy` to stay low and no width report to appear. A second case drops `clr` in the middle of a jitter pulse and expects the pulse to fall with no `jit_done`.

// File: rtl/trigsync_pkg.sv
package trigsync_pkg;
  // channel order on the chan_tick bus
  typedef enum logic [2:0] {CH_T0 = 3'd0, CH_A = 3'd1, CH_B = 3'd2, CH_C = 3'd3, CH_D = 3'd4} chan_e;

  localparam int DEF_NUM_CHAN = 5;
  localparam int DEF_DIV      = 8;
  localparam int DEF_SYNC     = 2;

  // longest delay is 1000 s of 12.5 ns ticks; downstream counters size from this
  localparam longint MAX_DELAY_TICKS = 64'd80_000_000_000;
  localparam int     CHAN_COUNT_W    = $clog2(MAX_DELAY_TICKS + 1);
endpackage

// File: rtl/trig_select.sv
module trig_select #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_trig_in,
  input  logic ext_en,
  input  logic trig_pol,
  output logic fall_q
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_lvl;
  logic                   line;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig_in};
  end

  assign ext_lvl = sync_q[SYNC_STAGES-1];

  // trigger is a falling edge of 'line'; pol=1 inverts the external level
  always_comb begin
    if (ext_en) line = trig_pol ? ~ext_lvl : ext_lvl;
    else        line = trig_pol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= line;
      fall_q <= prev_q & ~line;
    end
  end

  // R1 R2: a detected edge is a single-cycle event
  assert_edge_single_R1: assert property (@(posedge clk) disable iff (rst)
    fall_q |=> !fall_q);
endmodule

// File: rtl/master_phase.sv
module master_phase #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick_q
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PRE  = PW'(DIV - 2);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      tick_q  <= (phase_q == PRE);
    end
  end

  // R7: master strobe never lasts two sampling cycles
  assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/arm_ctrl.sv
module arm_ctrl #(
  parameter int NUM_CHAN = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall,
  input  logic                inhibit,
  input  logic                clr,
  input  logic                tick,
  output logic                busy_q,
  output logic                jit_q,
  output logic                start_q,
  output logic [NUM_CHAN-1:0] chan_tick
);
  logic stage0_q;
  logic accept;

  // clear wins over a trigger on the same edge
  assign accept = fall & ~inhibit & ~busy_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy_q   <= 1'b0;
      jit_q    <= 1'b0;
      stage0_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        jit_q  <= 1'b1;
      end
      if (tick) begin
        stage0_q <= busy_q;
        start_q  <= stage0_q;
        if (stage0_q) jit_q <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic en_q;
    always_ff @(posedge clk) begin
      if (rst || clr) en_q <= 1'b0;
      else            en_q <= start_q & tick;
    end
    assign chan_tick[c] = en_q;
  end

  // R5: busy holds until cleared
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !clr) |=> busy_q);
  // R4: inhibit keeps an idle block idle
  assert_inhibit_block_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && inhibit) |=> !busy_q);
  // R6: jitter pulse only inside a cycle
  assert_jit_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    jit_q |-> busy_q);
  // R8: clear empties the cycle
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!busy_q && !jit_q && !start_q));
  // R7: channel ticks only inside a cycle
  assert_tick_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (|chan_tick) |-> busy_q);
endmodule

// File: rtl/jitter_meter.sv
module jitter_meter #(
  parameter int DIV     = 8,
  parameter int WIDTH_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               jit,
  input  logic               start,
  output logic [WIDTH_W-1:0] width_q,
  output logic               done_q
);
  logic [WIDTH_W-1:0] cnt_q;
  logic               start_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      start_d_q <= 1'b0;
      width_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      cnt_q     <= jit ? cnt_q + 1'b1 : '0;
      start_d_q <= start;
      done_q    <= 1'b0;
      // report only a pulse that ended by reaching start
      if (start && !start_d_q) begin
        width_q <= cnt_q;
        done_q  <= 1'b1;
      end
    end
  end

  // R6: width lies in (DIV, 2*DIV]
  assert_width_range_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (width_q > WIDTH_W'(DIV) && width_q <= WIDTH_W'(2 * DIV)));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/trig_arm_sync.sv
module trig_arm_sync
  import trigsync_pkg::*;
#(
  parameter  int DIV         = DEF_DIV,
  parameter  int SYNC_STAGES = DEF_SYNC,
  parameter  int NUM_CHAN    = DEF_NUM_CHAN,
  localparam int WIDTH_W     = $clog2(2 * DIV + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext_trig_in,
  input  logic                ext_en,
  input  logic                trig_pol,
  input  logic                inhibit,
  input  logic                clr,
  output logic                master_tick,
  output logic                busy,
  output logic                jitter_pulse,
  output logic                start,
  output logic [NUM_CHAN-1:0] chan_tick,
  output logic [WIDTH_W-1:0]  jit_width,
  output logic                jit_done
);
  logic fall;

  trig_select #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk(clk), .rst(rst), .ext_trig_in(ext_trig_in), .ext_en(ext_en),
    .trig_pol(trig_pol), .fall_q(fall)
  );

  master_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst(rst), .tick_q(master_tick)
  );

  arm_ctrl #(.NUM_CHAN(NUM_CHAN)) u_arm (
    .clk(clk), .rst(rst), .fall(fall), .inhibit(inhibit), .clr(clr),
    .tick(master_tick), .busy_q(busy), .jit_q(jitter_pulse),
    .start_q(start), .chan_tick(chan_tick)
  );

  jitter_meter #(.DIV(DIV), .WIDTH_W(WIDTH_W)) u_meter (
    .clk(clk), .rst(rst), .jit(jitter_pulse), .start(start),
    .width_q(jit_width), .done_q(jit_done)
  );

  // R9: idle after reset
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!busy && !jitter_pulse && !start && chan_tick == '0));
endmodule

// File: tb/test_trig_arm_sync.sv
`timescale 1ns/1ps
module test_trig_arm_sync;
  localparam int DIV = 8;
  localparam int NC  = 5;
  localparam int WW  = $clog2(2 * DIV + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_trig_in = 1'b0, ext_en = 1'b0, trig_pol = 1'b1, inhibit = 1'b0, clr = 1'b0;
  logic master_tick, busy, jitter_pulse, start, jit_done;
  logic [NC-1:0] chan_tick;
  logic [WW-1:0] jit_width;

  int n_chk = 0, n_fail = 0, done_cnt = 0;
  int tick_cnt [NC];
  logic [WW-1:0] last_w = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  trig_arm_sync #(.DIV(DIV)) i_trig_arm_sync (
    .clk(clk), .rst(rst), .ext_trig_in(ext_trig_in), .ext_en(ext_en),
    .trig_pol(trig_pol), .inhibit(inhibit), .clr(clr), .master_tick(master_tick),
    .busy(busy), .jitter_pulse(jitter_pulse), .start(start),
    .chan_tick(chan_tick), .jit_width(jit_width), .jit_done(jit_done)
  );

  initial for (int i = 0; i < NC; i++) tick_cnt[i] = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (jit_done) begin
        done_cnt++;
        last_w = jit_width;
      end
      for (int i = 0; i < NC; i++) if (chan_tick[i]) tick_cnt[i]++;
    end
  end

  // bits: [6]ext_en [5]pol start [4]pol end [3]ext start [2]ext end [1]inhibit [0]expect busy
  localparam logic [6:0] VEC [0:8] = '{
    7'b1110101, 7'b1111000, 7'b1001001, 7'b1000100, 7'b0100101,
    7'b0010000, 7'b0111000, 7'b1110110, 7'b0100010 };
  localparam string TAG [0:8] = '{"R1", "R1", "R2", "R2", "R3", "R3", "R3", "R4", "R4"};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_width(input string req);
    n_chk++;
    if (!(last_w > DIV && last_w <= 2 * DIV)) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, last_w, DIV + 1, 2 * DIV);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int d0;
    int t0 [NC];
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R9 reset state
    chk("R9 busy", busy, 0);
    chk("R9 jitter", jitter_pulse, 0);
    chk("R9 start", start, 0);
    chk("R9 chan_tick", chan_tick, 0);
    chk("R9 jit_done", jit_done, 0);

    // table walk: R1..R4 plus R6 width per accepted trigger
    for (int v = 0; v < 9; v++) begin
      inhibit = 1'b1;
      ext_en = VEC[v][6]; trig_pol = VEC[v][5]; ext_trig_in = VEC[v][3];
      cyc(6);
      pulse_clr();
      inhibit = VEC[v][1];
      d0 = done_cnt;
      cyc(2);
      trig_pol = VEC[v][4]; ext_trig_in = VEC[v][2];
      cyc(8);
      chk({TAG[v], " busy"}, busy, VEC[v][0]);
      cyc(3 * DIV);
      chk({TAG[v], " R6 reports"}, done_cnt - d0, VEC[v][0]);
      if (VEC[v][0]) chk_width({TAG[v], " R6 width"});
    end

    // R7: no channel ticks while idle
    inhibit = 1'b1; ext_en = 1'b0; trig_pol = 1'b1;
    cyc(4); pulse_clr(); inhibit = 1'b0;
    for (int i = 0; i < NC; i++) t0[i] = tick_cnt[i];
    cyc(3 * DIV);
    for (int i = 0; i < NC; i++) chk("R7 idle ticks", tick_cnt[i] - t0[i], 0);

    // R10 latency of the internal trigger
    trig_pol = 1'b0;
    @(posedge clk); #1;
    chk("R10 busy after N", busy, 0);
    @(posedge clk); #1;
    chk("R10 busy after N+1", busy, 1);
    chk("R6 jitter rises with busy", jitter_pulse, 1);
    @(negedge clk);
    cyc(3 * DIV);
    chk("R6 start", start, 1);
    chk("R6 jitter ended", jitter_pulse, 0);

    // R7: one tick per master period on every channel
    for (int i = 0; i < NC; i++) t0[i] = tick_cnt[i];
    cyc(4 * DIV);
    for (int i = 0; i < NC; i++) chk("R7 ticks per channel", tick_cnt[i] - t0[i], 4);

    // R5: a new edge while busy is ignored
    d0 = done_cnt;
    trig_pol = 1'b1; cyc(3); trig_pol = 1'b0;
    cyc(3 * DIV);
    chk("R5 busy held", busy, 1);
    chk("R5 no new report", done_cnt - d0, 0);
    chk("R5 no new jitter", jitter_pulse, 0);

    // R8: clear stops the cycle and the ticks
    pulse_clr();
    chk("R8 busy cleared", busy, 0);
    chk("R8 start cleared", start, 0);
    for (int i = 0; i < NC; i++) t0[i] = tick_cnt[i];
    cyc(2 * DIV);
    chk("R8 ticks stopped", tick_cnt[0] - t0[0], 0);

    // R8: clear in the middle of a jitter pulse
    trig_pol = 1'b1; cyc(3);
    d0 = done_cnt;
    trig_pol = 1'b0;
    cyc(4);
    chk("R8 pulse running", jitter_pulse, 1);
    pulse_clr();
    chk("R8 pulse cut", jitter_pulse, 0);
    cyc(3 * DIV);
    chk("R8 no report after cut", done_cnt - d0, 0);

    // R8: clear on the same edge as acceptance
    trig_pol = 1'b1; cyc(3);
    d0 = done_cnt;
    trig_pol = 1'b0;  // edge detected at next edge N, accepted at N+1
    cyc(1);
    clr = 1'b1;       // high across edge N+1
    cyc(1);
    clr = 1'b0;
    cyc(3 * DIV);
    chk("R8 same-edge clear busy", busy, 0);
    chk("R8 same-edge clear report", done_cnt - d0, 0);

    finish_run();
  end
endmodule